// File: doc/BRIEF.md
# Overcurrent Fault Hiccup Controller

This block watches per-cycle overcurrent flags from the high-side and low-side power switches of a buck stage. It keeps them in a net up/down count. Each switching-cycle strobe raises the count when either switch reports overcurrent and lowers it when neither does. The count never goes below zero. When the net count reaches the trip value, the controller declares a fault, stops switching and starts a hiccup restart.

A hiccup restart is a run of dummy soft-start timeouts with switching held off, followed by one real soft-start attempt with switching enabled. The block asks the external soft-start ramp to begin each timeout with a one-cycle restart request, and counts the done pulses that come back. The number of dummy timeouts depends on the phase at the moment of the trip. A trip during normal operation gives one fewer dummy timeout than a trip while the startup indicator is high. If overcurrent trips again during the real attempt, a new hiccup run begins, and this repeats while the fault lasts. A real attempt that finishes without a trip clears the fault flag and returns the block to normal operation.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: On a cycle with `cyc_stb` high and switching enabled, the net count rises by one if `oc_hi` or `oc_lo` (or both) is high.
- R2: On a cycle with `cyc_stb` high, switching enabled and both flags low, the net count falls by one.
- R3: The net count saturates at zero. Strobes with no overcurrent at a count of zero leave it at zero, so no credit is stored.
- R4: When the count would reach TRIP_COUNT (default 3), the next cycle shows `fault`=1, `sw_en`=0 and a one-cycle `ss_restart` pulse, and the count is cleared.
- R5: A trip with `in_startup` low starts DUMMY_RUN (default 4) dummy timeouts. Each `ss_done` pulse ends one of them and produces a `ss_restart` pulse on the next cycle. `sw_en` goes back to 1 only after the last dummy timeout ends.
- R6: A trip with `in_startup` high starts DUMMY_START (default 5) dummy timeouts, with the same timing as R5.
- R7: A trip during the real soft-start attempt starts a new hiccup run, so the cycle repeats while overcurrent persists.
- R8: An `ss_done` pulse during the real attempt with no trip on that cycle gives `fault`=0 and `sw_en`=1 on the next cycle.
- R9: Overcurrent flags without `cyc_stb`, and `ss_done` pulses during normal operation, have no effect on any output.
- R10: While `rst_n` is low at a clock edge, the block returns to normal operation with the count at zero, `fault`=0, `sw_en`=1 and `ss_restart`=0.
- R11: Overcurrent strobes during dummy timeouts are ignored. The real attempt starts from a count of zero and needs TRIP_COUNT net events to trip again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_stb | input | 1 | One pulse per switching cycle |
| oc_hi | input | 1 | High-side switch overcurrent flag |
| oc_lo | input | 1 | Low-side switch overcurrent flag |
| ss_done | input | 1 | Soft-start timeout finished pulse |
| in_startup | input | 1 | High while the converter is in its startup phase |
| fault | output | 1 | Overcurrent fault declared |
| ss_restart | output | 1 | One-cycle request to start a soft-start timeout |
| sw_en | output | 1 | Switching enable |

## Verification
The net count is hidden, so its value can only be inferred from the strobe on which `fault` rises. The bench sweeps all 256 eight-strobe overcurrent patterns from reset, mixing the high-side, low-side and both-flag cases. It compares the trip point against an arithmetic model of the saturating count, which covers saturation at zero and the order of increments and decrements. The hardest situation to reach is a second trip inside a real attempt that follows a full dummy run. The bench gets there by giving exactly the expected number of `ss_done` pulses while injecting overcurrent strobes during the dummy timeouts. It then counts the strobes needed to trip again, for both the startup and the normal-operation dummy counts.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DUMMY = 2'd1,
        ST_REAL  = 2'd2
    } hic_state_e;
endpackage

// File: rtl/oc_net_counter.sv
module oc_net_counter #(
    parameter int TRIP_COUNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic oc,
    input  logic en,
    output logic trip
);
    localparam int CW = $clog2(TRIP_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIP_COUNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        trip = 1'b0;
        if (!en) begin
            r_d.cnt = '0;
        end else if (stb) begin
            if (oc) begin
                if (r_q.cnt == LAST) begin
                    trip    = 1'b1;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end else if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && oc && r_q.cnt != LAST) |=> r_q.cnt == $past(r_q.cnt) + CW'(1));
    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && !oc && r_q.cnt != '0) |=> r_q.cnt == $past(r_q.cnt) - CW'(1));
    assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && !oc && r_q.cnt == '0) |=> r_q.cnt == '0);
    assert_below_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(TRIP_COUNT));
    assert_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> r_q.cnt == '0);
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import ocp_hiccup_pkg::*;
#(
    parameter int DUMMY_RUN   = 4,
    parameter int DUMMY_START = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic ss_done,
    input  logic in_startup,
    output logic fault,
    output logic ss_restart,
    output logic sw_en
);
    localparam int MAXD = (DUMMY_START > DUMMY_RUN) ? DUMMY_START : DUMMY_RUN;
    localparam int LW   = $clog2(MAXD + 1);
    localparam logic [LW-1:0] N_RUN   = LW'(DUMMY_RUN);
    localparam logic [LW-1:0] N_START = LW'(DUMMY_START);

    typedef struct packed {
        hic_state_e    st;
        logic [LW-1:0] left;
        logic          fault;
        logic          restart;
    } seq_reg_t;

    seq_reg_t s_q, s_d;

    always_comb begin
        s_d         = s_q;
        s_d.restart = 1'b0;
        case (s_q.st)
            ST_RUN: begin
                if (trip) begin
                    s_d.st      = ST_DUMMY;
                    s_d.left    = in_startup ? N_START : N_RUN;
                    s_d.fault   = 1'b1;
                    s_d.restart = 1'b1;
                end
            end
            ST_DUMMY: begin
                if (ss_done) begin
                    s_d.restart = 1'b1;
                    if (s_q.left <= LW'(1)) begin
                        s_d.st   = ST_REAL;
                        s_d.left = '0;
                    end else begin
                        s_d.left = s_q.left - LW'(1);
                    end
                end
            end
            ST_REAL: begin
                if (trip) begin
                    s_d.st      = ST_DUMMY;
                    s_d.left    = in_startup ? N_START : N_RUN;
                    s_d.restart = 1'b1;
                end else if (ss_done) begin
                    s_d.st    = ST_RUN;
                    s_d.fault = 1'b0;
                end
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= ST_RUN;
            s_q.left    <= '0;
            s_q.fault   <= 1'b0;
            s_q.restart <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fault      = s_q.fault;
    assign ss_restart = s_q.restart;
    assign sw_en      = (s_q.st != ST_DUMMY);

    assert_trip_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (fault && ss_restart && !sw_en));
    assert_left_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.left <= LW'(MAXD));
    assert_last_dummy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && ss_done && s_q.left == LW'(1)) |=> (sw_en && ss_restart));
    assert_real_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_REAL && ss_done && !trip) |=> (!fault && sw_en));
    assert_fault_clears_only_after_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(s_q.st == ST_REAL));
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
    parameter int TRIP_COUNT  = 3,
    parameter int DUMMY_RUN   = 4,
    parameter int DUMMY_START = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic oc_hi,
    input  logic oc_lo,
    input  logic ss_done,
    input  logic in_startup,
    output logic fault,
    output logic ss_restart,
    output logic sw_en
);
    logic trip;
    logic oc_any;

    assign oc_any = oc_hi | oc_lo;

    oc_net_counter #(.TRIP_COUNT(TRIP_COUNT)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (cyc_stb),
        .oc   (oc_any),
        .en   (sw_en),
        .trip (trip)
    );

    hiccup_seq #(.DUMMY_RUN(DUMMY_RUN), .DUMMY_START(DUMMY_START)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip      (trip),
        .ss_done   (ss_done),
        .in_startup(in_startup),
        .fault     (fault),
        .ss_restart(ss_restart),
        .sw_en     (sw_en)
    );

    assert_quiet_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !ss_done) |=> ($stable(fault) && $stable(sw_en) && !ss_restart));
endmodule

// File: tb/test_ocp_hiccup_ctrl.sv
module test_ocp_hiccup_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, oc_hi = 1'b0, oc_lo = 1'b0, ss_done = 1'b0, in_startup = 1'b0;
    logic fault, ss_restart, sw_en;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ocp_hiccup_ctrl i_ocp_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .oc_hi(oc_hi), .oc_lo(oc_lo),
        .ss_done(ss_done), .in_startup(in_startup),
        .fault(fault), .ss_restart(ss_restart), .sw_en(sw_en)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc_stb = 1'b0; oc_hi = 1'b0; oc_lo = 1'b0; ss_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one strobe; outputs sampled at the negedge right after the capturing edge
    task automatic strobe(input logic hi, input logic lo);
        cyc_stb = 1'b1; oc_hi = hi; oc_lo = lo;
        @(negedge clk);
        cyc_stb = 1'b0; oc_hi = 1'b0; oc_lo = 1'b0;
    endtask

    task automatic done_pulse();
        ss_done = 1'b1;
        @(negedge clk);
        ss_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // full hiccup walk for one phase setting
    task automatic hiccup_walk(input logic startup, input int ndum, input string tg);
        do_reset();
        in_startup = startup;
        strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        check("R4 no fault before third event", fault, 1'b0);
        strobe(1'b1, 1'b1);
        check("R4 fault on trip", fault, 1'b1);
        check("R4 sw_en off on trip", sw_en, 1'b0);
        check("R4 restart pulse on trip", ss_restart, 1'b1);
        idle(1);
        check("R4 restart pulse one cycle", ss_restart, 1'b0);
        for (int k = 1; k <= ndum; k++) begin
            strobe(1'b1, 1'b1);   // ignored while dummy timeouts run (R11)
            done_pulse();
            check({tg, " restart per dummy"}, ss_restart, 1'b1);
            check({tg, " sw_en after dummy"}, sw_en, (k == ndum));
        end
        idle(1);
        // real attempt: count starts from zero (R11)
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        check("R11 real attempt not tripped after two", sw_en, 1'b1);
        strobe(1'b0, 1'b1);
        check("R7 retrip in real attempt", sw_en, 1'b0);
        check("R7 retrip restart pulse", ss_restart, 1'b1);
        check("R7 fault held", fault, 1'b1);
        for (int k = 1; k <= ndum; k++) done_pulse();
        check({tg, " second run reaches real"}, sw_en, 1'b1);
        idle(1);
        done_pulse();
        check("R8 fault cleared", fault, 1'b0);
        check("R8 switching on", sw_en, 1'b1);
        check("R8 no restart on completion", ss_restart, 1'b0);
    endtask

    initial begin
        #2_000_000ns;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        check("R10 fault after reset", fault, 1'b0);
        check("R10 sw_en after reset", sw_en, 1'b1);
        check("R10 restart after reset", ss_restart, 1'b0);

        // sweep all 8-strobe overcurrent patterns against an arithmetic model
        for (int p = 0; p < 256; p++) begin
            int cnt;
            logic tripped;
            do_reset();
            in_startup = p[0];
            cnt = 0;
            tripped = 1'b0;
            for (int i = 0; i < 8; i++) begin
                logic b;
                b = p[i];
                strobe(b && (i % 2 == 0), b && ((i % 2 == 1) || i == 6));
                if (!tripped) begin
                    if (b) begin
                        if (cnt == 2) begin tripped = 1'b1; cnt = 0; end
                        else cnt++;
                    end else if (cnt > 0) begin
                        cnt--;
                    end
                end
                check("R1 R2 R3 R4 sweep fault", fault, tripped);
                check("R4 sweep sw_en", sw_en, !tripped);
            end
        end

        // R9: flags without strobe, done pulses in normal operation
        do_reset();
        oc_hi = 1'b1; oc_lo = 1'b1;
        idle(6);
        oc_hi = 1'b0; oc_lo = 1'b0;
        check("R9 flags without strobe", fault, 1'b0);
        done_pulse();
        check("R9 done in normal no restart", ss_restart, 1'b0);
        check("R9 done in normal fault", fault, 1'b0);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        check("R9 count unaffected by unstrobed flags", fault, 1'b0);
        strobe(1'b1, 1'b0);
        check("R9 trips on third strobe", fault, 1'b1);

        // R3: long run of clean strobes stores no credit
        do_reset();
        for (int i = 0; i < 10; i++) strobe(1'b0, 1'b0);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        check("R3 no credit below zero", fault, 1'b0);
        strobe(1'b0, 1'b1);
        check("R3 trip after three", fault, 1'b1);

        hiccup_walk(1'b0, 4, "R5");
        hiccup_walk(1'b1, 5, "R6");

        // R5: normal-op trip must not end dummies early at three
        do_reset();
        in_startup = 1'b0;
        for (int i = 0; i < 3; i++) strobe(1'b1, 1'b0);
        for (int k = 0; k < 3; k++) done_pulse();
        check("R5 still dummy after three", sw_en, 1'b0);

        // R10: reset during hiccup
        do_reset();
        check("R10 reset exits hiccup sw_en", sw_en, 1'b1);
        check("R10 reset exits hiccup fault", fault, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule